// File: doc/BRIEF.md
# I2C Slave Byte Engine with Automatic Clock Stretching

This block is the serial engine of a microcontroller's I2C slave peripheral. It watches the open-drain SCL and SDA lines through input synchronisers and detects START and STOP. It collects the first byte after a START and compares its upper seven bits with a programmable own address. It then moves data bytes MSB first through a single data register that the CPU shares with the bus. Receive and transmit both go through this one register.

After every acknowledged byte the engine raises an interrupt flag. It then pulls SCL low once the acknowledge clock ends, and keeps it low until the CPU services the data register. In receive mode the CPU services it by reading. In transmit mode the CPU services it by writing. A service routine can therefore run at its own pace, because the bus waits for it. The CPU side is a set of single-cycle strobes plus the register and flag outputs. The bus side is a pair of active-high pull-down enables.

Top module: `i2c_slave_stretch`

## Requirements
- R1: After reset the data register and the address register read 00h. The interrupt, address-matched and transmit flags are 0, and neither SCL nor SDA is pulled low.
- R2: The address register changes only on a CPU address write. Bits 7:1 hold the 7-bit own address and bit 0 is unused. No bus activity alters the register.
- R3: When the 7 address bits received after a START equal address-register bits 7:1, the engine does three things. It pulls SDA low on the 9th clock (ACK). It sets both the interrupt flag and the address-matched flag. It sets the transmit flag to the 8th received bit, where 1 selects transmit and 0 selects receive.
- R4: On an address mismatch the engine leaves SDA released on the 9th clock (NACK) and sets no flag. It then ignores every later byte until the next START.
- R5: In receive mode the engine shifts bits in MSB first and places the completed byte in the data register. It sets the interrupt flag and pulls SDA low on the 9th clock.
- R6: After every acknowledged byte, including the address byte, the engine holds SCL low from the falling edge that ends the 9th clock. The hold lasts while the interrupt flag stays set.
- R7: In receive mode a CPU read of the data register clears the interrupt flag and releases SCL. A CPU write in receive mode releases nothing.
- R8: In transmit mode a CPU write clears the interrupt flag, releases SCL and supplies the byte. The engine then sends that byte MSB first.
- R9: When the master answers a transmitted byte with NACK, the engine releases SDA and sets no interrupt. It also imposes no hold, and it stays passive until STOP or START.
- R10: A START in the middle of a byte restarts the bit count, so the byte that follows it is taken as a fresh address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | CPU write strobe for the data register |
| data_rd | input | 1 | CPU read strobe for the data register |
| addr_wr | input | 1 | CPU write strobe for the address register |
| wdata | input | 8 | CPU write data |
| data_q | output | 8 | Data register contents |
| addr_q | output | 8 | Address register contents (bits 7:1 are the address) |
| irq | output | 1 | Byte-complete interrupt flag |
| addr_match | output | 1 | Own address recognised since the last START |
| xmit | output | 1 | 1 = transmit data phase, 0 = receive |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Several rules are checked on every cycle. A SCL hold must always be backed by a pending interrupt. A servicing access made during a hold must clear the flag and then drop the hold, in the right direction for the current mode. The address register must never move without a CPU write, and an address match must always raise the interrupt in the same cycle.

Some behaviour only the bench's bus scenarios can show. These are the bit order on the wire and the ACK/NACK levels on the 9th clock. They also include ignoring traffic after a mismatch, a write in receive mode leaving the hold in place, the passive state after a master NACK, and recovery through a repeated START in the middle of a byte.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SETUP,
    ST_ACK_DRIVE,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_MACK_DONE,
    ST_IGNORE
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
    end else begin
      for (int k = STAGES - 1; k > 0; k--) pipe[k] <= pipe[k-1];
      pipe[0] <= d;
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // SDA edges while SCL stays high are bus conditions, not data
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_slave_stretch.sv
module i2c_slave_stretch #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              addr_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] addr_q,
  output logic              irq,
  output logic              addr_match,
  output logic              xmit,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  import i2cs_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);

  logic [1:0] line_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
  );

  i2cs_busmon u_mon (
    .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shift;
  logic [DATA_W-1:0] shift_in;
  logic              stretch;
  logic              svc;
  logic              hit_now;
  logic [DATA_W-1:0] tx_load;

  assign shift_in = {shift[DATA_W-2:0], line_s[0]};
  assign hit_now  = (shift_in[DATA_W-1:1] == addr_q[DATA_W-1:1]);
  assign svc      = irq & ((data_wr & xmit) | (data_rd & ~xmit));
  assign tx_load  = data_wr ? wdata : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shift      <= '0;
      data_q     <= '0;
      addr_q     <= '0;
      irq        <= 1'b0;
      addr_match <= 1'b0;
      xmit       <= 1'b0;
      stretch    <= 1'b0;
      scl_oe     <= 1'b0;
      sda_oe     <= 1'b0;
    end else begin
      scl_oe <= stretch;
      sda_oe <= (state == ST_ACK_DRIVE) || (state == ST_TX && !shift[DATA_W-1]);

      if (addr_wr) addr_q <= wdata;
      if (data_wr) data_q <= wdata;
      if (svc) begin
        irq     <= 1'b0;
        stretch <= 1'b0;
        if (xmit && state == ST_TX) shift <= wdata;
      end

      if (stop_det) begin
        state   <= ST_IDLE;
        cnt     <= '0;
        stretch <= 1'b0;
      end else if (start_det) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        addr_match <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            shift <= shift_in;
            cnt   <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) begin
              if (hit_now) begin
                addr_match <= 1'b1;
                irq        <= 1'b1;
                xmit       <= shift_in[0];
                state      <= ST_ACK_SETUP;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_RX: if (scl_rise) begin
            shift <= shift_in;
            cnt   <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) begin
              data_q <= shift_in;
              irq    <= 1'b1;
              state  <= ST_ACK_SETUP;
            end
          end
          ST_ACK_SETUP: if (scl_fall) state <= ST_ACK_DRIVE;
          ST_ACK_DRIVE: if (scl_fall) begin
            cnt     <= '0;
            stretch <= irq & ~svc;
            state   <= xmit ? ST_TX : ST_RX;
            if (xmit) shift <= tx_load;
          end
          ST_TX: begin
            if (scl_rise) cnt <= cnt + CNT_W'(1);
            if (scl_fall) begin
              if (cnt == FULL_CNT) state <= ST_MACK;
              else shift <= {shift[DATA_W-2:0], 1'b0};
            end
          end
          ST_MACK: if (scl_rise) begin
            if (!line_s[0]) begin
              irq   <= 1'b1;
              state <= ST_MACK_DONE;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_MACK_DONE: if (scl_fall) begin
            cnt     <= '0;
            stretch <= irq & ~svc;
            shift   <= tx_load;
            state   <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              data_wr,
  input logic              data_rd,
  input logic              addr_wr,
  input logic [DATA_W-1:0] addr_q,
  input logic              irq,
  input logic              addr_match,
  input logic              xmit,
  input logic              scl_oe
);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_wr |=> $stable(addr_q));

  // R3
  match_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_match) |-> irq);

  // R6
  hold_irq_chk: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> $past(irq));

  // R7
  rx_release_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && data_rd && !xmit) |=> !irq);

  // R8
  tx_release_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && data_wr && xmit) |=> !irq ##1 !scl_oe);
endmodule

bind i2c_slave_stretch i2cs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .data_wr(data_wr), .data_rd(data_rd),
  .addr_wr(addr_wr), .addr_q(addr_q), .irq(irq),
  .addr_match(addr_match), .xmit(xmit), .scl_oe(scl_oe)
);

// File: tb/i2c_slave_stretch_tb.sv
module i2c_slave_stretch_tb;
  localparam int Q = 10;
  localparam logic [7:0] OWN = 8'hB4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_wr = 1'b0, data_rd = 1'b0, addr_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] data_q, addr_q;
  logic irq, addr_match, xmit, scl_oe, sda_oe;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_stretch u_dut (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_rd(data_rd),
    .addr_wr(addr_wr), .wdata(wdata), .data_q(data_q), .addr_q(addr_q),
    .irq(irq), .addr_match(addr_match), .xmit(xmit),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // {expect_match, address byte, data byte}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'hB4, 8'hA5},
    {1'b0, 8'hB6, 8'h11},
    {1'b1, 8'hB4, 8'h3C},
    {1'b0, 8'h34, 8'hFF},
    {1'b1, 8'hB4, 8'h00},
    {1'b1, 8'hB4, 8'h81}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_scl_high(); wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_scl_high(); wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_scl_high(); wait_q();
    s = sda_line;
    scl_m = 1'b0; wait_q();
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic cpu_write(input logic [7:0] v);
    @(negedge clk); data_wr = 1'b1; wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic cpu_read();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 data", data_q, 8'h00);
    chk("R1 addr", addr_q, 8'h00);
    chk("R1 flags", {irq, addr_match, xmit}, 3'b000);
    chk("R1 drivers", {scl_oe, sda_oe}, 2'b00);

    @(negedge clk); addr_wr = 1'b1; wdata = OWN;
    @(negedge clk); addr_wr = 1'b0;
    chk("R2 addr write", addr_q, OWN);

    // vector table: master-write transactions
    for (int v = 0; v < 6; v++) begin
      bus_start();
      write_byte(VEC[v][15:8], ack);
      if (VEC[v][16]) begin
        chk("R3 ack", ack, 1'b1);
        chk("R3 flags", {irq, addr_match, xmit}, 3'b110);
        chk("R6 hold after addr", scl_oe, 1'b1);
        cpu_read();
        @(negedge clk);
        chk("R7 read releases", {irq, scl_oe}, 2'b00);
        write_byte(VEC[v][7:0], ack);
        chk("R5 ack", ack, 1'b1);
        chk("R5 data", data_q, VEC[v][7:0]);
        chk("R5 irq", irq, 1'b1);
        chk("R6 hold after data", scl_oe, 1'b1);
        cpu_write(8'h77);
        @(negedge clk);
        chk("R7 write keeps hold", {irq, scl_oe}, 2'b11);
        cpu_read();
        @(negedge clk);
        chk("R7 read releases data", {irq, scl_oe}, 2'b00);
      end else begin
        chk("R4 nack", ack, 1'b0);
        chk("R4 no flags", {irq, addr_match}, 2'b00);
        write_byte(OWN, ack);
        chk("R4 ignored byte", ack, 1'b0);
        chk("R4 still no flags", {irq, addr_match, scl_oe}, 3'b000);
      end
      bus_stop();
    end

    // transmit mode
    bus_start();
    write_byte(OWN | 8'h01, ack);
    chk("R3 read ack", ack, 1'b1);
    chk("R3 xmit flag", {irq, addr_match, xmit}, 3'b111);
    chk("R6 hold tx addr", scl_oe, 1'b1);
    cpu_write(8'hC3);
    @(negedge clk);
    chk("R8 write releases", {irq, scl_oe}, 2'b00);
    read_byte(1'b1, rb);
    chk("R8 byte out", rb, 8'hC3);
    chk("R6 hold tx data", {irq, scl_oe}, 2'b11);
    cpu_write(8'h5E);
    @(negedge clk);
    chk("R8 second release", {irq, scl_oe}, 2'b00);
    read_byte(1'b0, rb);
    chk("R8 second byte", rb, 8'h5E);
    chk("R9 after nack", {irq, scl_oe, sda_oe}, 3'b000);
    read_byte(1'b0, rb);
    chk("R9 passive", rb, 8'hFF);
    bus_stop();

    // repeated START in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) clk_bit(1'b1, ack);
    bus_start();
    write_byte(OWN, ack);
    chk("R10 restart ack", ack, 1'b1);
    chk("R10 restart flags", {irq, addr_match}, 2'b11);
    cpu_read();
    @(negedge clk);
    bus_stop();

    chk("R2 addr kept", addr_q, OWN);

    done = 1;
    summary();
    $finish;
  end
endmodule